// File: doc/BRIEF.md
# Zero-Crossing Resonant Period Calibrator

This block measures the mechanical resonant period of a vibration actuator. Time is counted in strobes of the PWM input clock, and the only measured signal is a 1-bit back-EMF comparator. A start strobe opens a calibration event. The block first waits while the actuator is driven for a programmed number of nominal periods. It then waits out a blanking delay derived from the nominal divisor, and after that it seeks four zero crossings of the comparator. A crossing counts only when the comparator has shown the new level a programmed number of times, so short jitter near the edge does not end the search early.

The crossing timestamps give two period estimates, one from crossings 1 and 3 and one from crossings 2 and 4. The final divisor is either the first estimate or the mean of the two. It is accepted only if it lies within a power-of-two band around the nominal divisor; otherwise the nominal value is used. The block also reports the estimates, the timestamp of the first crossing, the level counters, the current state, a timeout flag and a first-calibration flag. An accepted divisor can be kept and reused as the starting value when a later event skips calibration.

Top module: `zxc_calibrator`

## Requirements
- R1: After reset, state_o is 0 (idle), div_o is 0, fail_o is 0, first_cal_o is 1, and hi_cnt_o, lo_cnt_o and lvl_cnt_o are 0.
- R2: state_o uses the codes 0 idle, 1 drive, 2 delay, 3 to 6 for seeking crossings 1 to 4, 7 compute, 8 done and 9 fail. A start strobe is accepted in idle, done or fail. When en_i is low, state_o is 0 on the following clock.
- R3: The drive phase lasts (drive_pulses_i+1)*nom_div_i ticks. The delay phase that follows lasts nom_div_i>>(3+dly_sel_i) ticks, with a minimum of 1. The comparator level sampled on the last delay tick becomes the starting level.
- R4: The crossing timestamp counts 0, 1, 2, … on successive seek ticks. A crossing is declared on the tick where the running count of samples at the level opposite to the current level reaches zx_thresh_i. Samples at the current level do not clear that count. A threshold of 0 behaves like 1. first_tag_o is the timestamp of crossing 1.
- R5: est_a_o is the timestamp of crossing 3 minus that of crossing 1. est_b_o is the timestamp of crossing 4 minus that of crossing 2.
- R6: With avg_en_i high the candidate divisor is (est_a+est_b)>>1. With avg_en_i low it is est_a.
- R7: margin_sel_i 0 accepts any candidate. Codes 1 to 7 accept only when |candidate-nom_div_i| <= nom_div_i>>(9-code), and codes above 7 behave like 7. A rejected candidate leaves div_o equal to nom_div_i.
- R8: If four crossings are not found before the timestamp reaches 3*nom_div_i, the block enters fail (9), sets fail_o and drives div_o to nom_div_i. A later start clears fail_o.
- R9: A start with cal_en_i low moves straight to done. div_o then takes the starting value: the kept divisor if keeping is enabled and one has been kept, otherwise nom_div_i.
- R10: With keep_en_i high, an accepted divisor is kept for later events. With keep_en_i low, every event starts from nom_div_i.
- R11: During the search for crossing 1, hi_cnt_o and lo_cnt_o count the high and low samples, saturating at 255. The timestamp saturates at 65535. After a crossing is declared, lvl_cnt_o reads 0 and last_lvl_o holds the new level.
- R12: first_cal_o stays 1 from reset until the first measuring event ends in done or fail, and is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low forces idle |
| start_i | input | 1 | Starts a calibration event |
| pwm_tick_i | input | 1 | One-cycle strobe per PWM input clock period |
| bemf_cmp_i | input | 1 | Back-EMF comparator output |
| nom_div_i | input | 16 | Nominal divisor, in ticks per resonant period |
| dly_sel_i | input | 2 | Blanking delay code |
| zx_thresh_i | input | 8 | Samples at the new level needed to declare a crossing |
| margin_sel_i | input | 4 | Acceptance band code |
| avg_en_i | input | 1 | Average the two estimates |
| cal_en_i | input | 1 | Run a measurement (low: bypass) |
| keep_en_i | input | 1 | Keep an accepted divisor for later events |
| drive_pulses_i | input | 3 | Drive phase length minus one, in nominal periods |
| div_o | output | 16 | Final divisor |
| est_a_o | output | 16 | Estimate from crossings 1 and 3 |
| est_b_o | output | 16 | Estimate from crossings 2 and 4 |
| first_tag_o | output | 16 | Timestamp of crossing 1 |
| hi_cnt_o | output | 8 | High samples seen while seeking crossing 1 |
| lo_cnt_o | output | 8 | Low samples seen while seeking crossing 1 |
| lvl_cnt_o | output | 8 | Count of samples at the new level |
| last_lvl_o | output | 1 | Current reference level |
| first_cal_o | output | 1 | First calibration since reset pending |
| state_o | output | 4 | State code |
| fail_o | output | 1 | Crossing search timed out |

## Verification
A wrong drive or delay length moves every timestamp by the same amount. It therefore shows first in first_tag_o, while the estimates stay unchanged. A fault in the level accumulator moves single crossings, so est_a_o and est_b_o disagree, and the fault shows as soon as the event reaches done. The stimulus is a square wave with one glitch placed to shorten only crossing 4. Because of this, the averaging and margin paths produce different divisors that can be told apart. A window or saturation fault shows as a wrong state code (8 instead of 9) or as a counter that reads other than 255 after one long event.

// File: rtl/zxc_pkg.sv
package zxc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_DRIVE   = 4'd1,
    ST_DELAY   = 4'd2,
    ST_SEEK1   = 4'd3,
    ST_SEEK2   = 4'd4,
    ST_SEEK3   = 4'd5,
    ST_SEEK4   = 4'd6,
    ST_COMPUTE = 4'd7,
    ST_DONE    = 4'd8,
    ST_FAIL    = 4'd9
  } zxc_state_e;

  localparam int unsigned NUM_XINGS = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_XINGS);
endpackage

// File: rtl/zxc_fsm.sv
module zxc_fsm
  import zxc_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned PULSE_W = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic               cal_en_i,
  input  logic [DIV_W-1:0]   nom_div_i,
  input  logic [SEL_W-1:0]   dly_sel_i,
  input  logic [PULSE_W-1:0] pulses_i,
  input  logic               found_i,
  output zxc_state_e         state_o,
  output logic [DIV_W-1:0]   tag_o,
  output logic [IDX_W-1:0]   seek_idx_o,
  output logic               arm_o,
  output logic               seek_o,
  output logic               seek_first_o,
  output logic               compute_o,
  output logic               bypass_o,
  output logic               fail_evt_o,
  output logic               fail_o,
  output logic               first_o
);
  localparam int unsigned PH_W  = DIV_W + PULSE_W + 1;
  localparam int unsigned WIN_W = DIV_W + 2;

  zxc_state_e       state_q;
  logic [PH_W-1:0]  cnt_q;
  logic [DIV_W-1:0] tag_q;
  logic             fail_q, first_q;

  logic [PH_W-1:0]  drive_len, cnt_nxt;
  logic [DIV_W-1:0] dly_raw, dly_eff, win;
  logic [WIN_W-1:0] win_full;
  logic             in_seek, timeout, idle_like;

  assign drive_len = (PH_W'(pulses_i) + PH_W'(1)) * PH_W'(nom_div_i);
  assign dly_raw   = DIV_W'(nom_div_i >> (32'd3 + 32'(dly_sel_i)));
  assign dly_eff   = (dly_raw == '0) ? DIV_W'(1) : dly_raw;
  assign win_full  = WIN_W'(nom_div_i) * WIN_W'(3);
  assign win       = (win_full > WIN_W'({DIV_W{1'b1}})) ? {DIV_W{1'b1}} : win_full[DIV_W-1:0];
  assign cnt_nxt   = cnt_q + PH_W'(1);

  assign in_seek   = (state_q == ST_SEEK1) || (state_q == ST_SEEK2) ||
                     (state_q == ST_SEEK3) || (state_q == ST_SEEK4);
  assign timeout   = in_seek && (tag_q >= win);
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);

  assign seek_o       = en_i && in_seek && !timeout;
  assign seek_first_o = state_q == ST_SEEK1;
  assign seek_idx_o   = IDX_W'(4'(state_q) - 4'(ST_SEEK1));
  assign arm_o        = en_i && (state_q == ST_DELAY) && tick_i && (cnt_nxt >= PH_W'(dly_eff));
  assign compute_o    = en_i && (state_q == ST_COMPUTE);
  assign bypass_o     = en_i && start_i && !cal_en_i && idle_like;
  assign fail_evt_o   = en_i && tick_i && timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tag_q   <= '0;
      fail_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start_i) begin
            fail_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= cal_en_i ? ST_DRIVE : ST_DONE;
          end
        end
        ST_DRIVE: begin
          if (tick_i) begin
            if (cnt_nxt >= drive_len) begin
              cnt_q   <= '0;
              state_q <= ST_DELAY;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
        end
        ST_DELAY: begin
          if (tick_i) begin
            if (arm_o) begin
              tag_q   <= '0;
              state_q <= ST_SEEK1;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
        end
        ST_SEEK1, ST_SEEK2, ST_SEEK3, ST_SEEK4: begin
          if (tick_i) begin
            if (timeout) begin
              fail_q  <= 1'b1;
              first_q <= 1'b0;
              state_q <= ST_FAIL;
            end else begin
              if (tag_q != {DIV_W{1'b1}}) tag_q <= tag_q + DIV_W'(1);
              if (found_i) begin
                case (state_q)
                  ST_SEEK1: state_q <= ST_SEEK2;
                  ST_SEEK2: state_q <= ST_SEEK3;
                  ST_SEEK3: state_q <= ST_SEEK4;
                  default:  state_q <= ST_COMPUTE;
                endcase
              end
            end
          end
        end
        ST_COMPUTE: begin
          first_q <= 1'b0;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;
  assign fail_o  = fail_q;
  assign first_o = first_q;

  // R2
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    4'(state_q) <= 4'd9);

  // R2
  en_drop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);

  // R8
  fail_from_seek_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(in_seek));

  // R11
  tag_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_seek && $past(in_seek)) |-> tag_q >= $past(tag_q));
endmodule

// File: rtl/zxc_edge_finder.sv
module zxc_edge_finder #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             active_i,
  input  logic             first_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             found_o,
  output logic             last_o,
  output logic [CNT_W-1:0] lvl_cnt_o,
  output logic [CNT_W-1:0] hi_cnt_o,
  output logic [CNT_W-1:0] lo_cnt_o
);
  logic             last_q;
  logic [CNT_W-1:0] lvl_q, hi_q, lo_q, thr_eff;
  logic [CNT_W:0]   lvl_plus;
  logic             sample, differ;

  assign thr_eff  = (thresh_i == '0) ? CNT_W'(1) : thresh_i;
  assign lvl_plus = {1'b0, lvl_q} + (CNT_W+1)'(1);
  assign sample   = tick_i && active_i;
  assign differ   = cmp_i != last_q;
  assign found_o  = sample && differ && (lvl_plus >= {1'b0, thr_eff});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      lvl_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (arm_i) begin
      last_q <= cmp_i;
      lvl_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (sample) begin
      if (first_i) begin
        if (cmp_i && hi_q != '1)  hi_q <= hi_q + CNT_W'(1);
        if (!cmp_i && lo_q != '1) lo_q <= lo_q + CNT_W'(1);
      end
      if (found_o) begin
        last_q <= ~last_q;
        lvl_q  <= '0;
      end else if (differ && lvl_q != '1) begin
        lvl_q <= lvl_plus[CNT_W-1:0];
      end
    end
  end

  assign last_o    = last_q;
  assign lvl_cnt_o = lvl_q;
  assign hi_cnt_o  = hi_q;
  assign lo_cnt_o  = lo_q;

  // R11
  hi_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q == '1 && !arm_i) |=> hi_q == '1);

  // R11
  lo_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q == '1 && !arm_i) |=> lo_q == '1);

  // R4
  level_flip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_q) |-> $past(found_o || arm_i));

  // R11
  found_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> lvl_q == '0);
endmodule

// File: rtl/zxc_result.sv
module zxc_result
  import zxc_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned MARGIN_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                found_i,
  input  logic [IDX_W-1:0]    seek_idx_i,
  input  logic [DIV_W-1:0]    tag_i,
  input  logic                compute_i,
  input  logic                bypass_i,
  input  logic                fail_i,
  input  logic [DIV_W-1:0]    nom_div_i,
  input  logic [MARGIN_W-1:0] margin_i,
  input  logic                avg_en_i,
  input  logic                keep_en_i,
  output logic [DIV_W-1:0]    div_o,
  output logic [DIV_W-1:0]    est_a_o,
  output logic [DIV_W-1:0]    est_b_o,
  output logic [DIV_W-1:0]    first_tag_o
);
  localparam int unsigned MAX_CODE = 7;

  logic [DIV_W-1:0] t1_q, t2_q, a_q, b_q, div_q, kept_q;
  logic             kept_vld_q;
  logic [DIV_W:0]   sum;
  logic [DIV_W-1:0] cand, diff, tol;
  logic [MARGIN_W-1:0] code;
  logic             accept;

  assign sum    = {1'b0, a_q} + {1'b0, b_q};
  assign cand   = avg_en_i ? DIV_W'(sum >> 1) : a_q;
  assign diff   = (cand >= nom_div_i) ? (cand - nom_div_i) : (nom_div_i - cand);
  assign code   = (margin_i > MARGIN_W'(MAX_CODE)) ? MARGIN_W'(MAX_CODE) : margin_i;
  assign tol    = DIV_W'(nom_div_i >> (32'd9 - 32'(code)));
  assign accept = (margin_i == '0) || (diff <= tol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q <= '0;
      t2_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (found_i) begin
      case (seek_idx_i)
        IDX_W'(0): t1_q <= tag_i;
        IDX_W'(1): t2_q <= tag_i;
        IDX_W'(2): a_q  <= tag_i - t1_q;
        default:   b_q  <= tag_i - t2_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= '0;
      kept_q     <= '0;
      kept_vld_q <= 1'b0;
    end else if (compute_i) begin
      div_q <= accept ? cand : nom_div_i;
      if (accept && keep_en_i) begin
        kept_q     <= cand;
        kept_vld_q <= 1'b1;
      end
    end else if (bypass_i) begin
      div_q <= (keep_en_i && kept_vld_q) ? kept_q : nom_div_i;
    end else if (fail_i) begin
      div_q <= nom_div_i;
    end
  end

  assign div_o       = div_q;
  assign est_a_o     = a_q;
  assign est_b_o     = b_q;
  assign first_tag_o = t1_q;

  // R7
  div_update_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $past(compute_i || bypass_i || fail_i));

  // R8
  fail_loads_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !compute_i && !bypass_i) |=> div_q == $past(nom_div_i));

  // R10
  keep_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kept_vld_q) |-> $past(keep_en_i && compute_i));
endmodule

// File: rtl/zxc_calibrator.sv
module zxc_calibrator
  import zxc_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MARGIN_W = 4,
  parameter int unsigned PULSE_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                start_i,
  input  logic                pwm_tick_i,
  input  logic                bemf_cmp_i,
  input  logic [DIV_W-1:0]    nom_div_i,
  input  logic [SEL_W-1:0]    dly_sel_i,
  input  logic [CNT_W-1:0]    zx_thresh_i,
  input  logic [MARGIN_W-1:0] margin_sel_i,
  input  logic                avg_en_i,
  input  logic                cal_en_i,
  input  logic                keep_en_i,
  input  logic [PULSE_W-1:0]  drive_pulses_i,
  output logic [DIV_W-1:0]    div_o,
  output logic [DIV_W-1:0]    est_a_o,
  output logic [DIV_W-1:0]    est_b_o,
  output logic [DIV_W-1:0]    first_tag_o,
  output logic [CNT_W-1:0]    hi_cnt_o,
  output logic [CNT_W-1:0]    lo_cnt_o,
  output logic [CNT_W-1:0]    lvl_cnt_o,
  output logic                last_lvl_o,
  output logic                first_cal_o,
  output logic [3:0]          state_o,
  output logic                fail_o
);
  zxc_state_e       state;
  logic [DIV_W-1:0] tag;
  logic [IDX_W-1:0] seek_idx;
  logic             arm, seek, seek_first, compute, bypass, fail_evt, found;

  zxc_fsm #(.DIV_W(DIV_W), .PULSE_W(PULSE_W), .SEL_W(SEL_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .start_i      (start_i),
    .tick_i       (pwm_tick_i),
    .cal_en_i     (cal_en_i),
    .nom_div_i    (nom_div_i),
    .dly_sel_i    (dly_sel_i),
    .pulses_i     (drive_pulses_i),
    .found_i      (found),
    .state_o      (state),
    .tag_o        (tag),
    .seek_idx_o   (seek_idx),
    .arm_o        (arm),
    .seek_o       (seek),
    .seek_first_o (seek_first),
    .compute_o    (compute),
    .bypass_o     (bypass),
    .fail_evt_o   (fail_evt),
    .fail_o       (fail_o),
    .first_o      (first_cal_o)
  );

  zxc_edge_finder #(.CNT_W(CNT_W)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (pwm_tick_i),
    .arm_i     (arm),
    .active_i  (seek),
    .first_i   (seek_first),
    .cmp_i     (bemf_cmp_i),
    .thresh_i  (zx_thresh_i),
    .found_o   (found),
    .last_o    (last_lvl_o),
    .lvl_cnt_o (lvl_cnt_o),
    .hi_cnt_o  (hi_cnt_o),
    .lo_cnt_o  (lo_cnt_o)
  );

  zxc_result #(.DIV_W(DIV_W), .MARGIN_W(MARGIN_W)) u_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .found_i     (found),
    .seek_idx_i  (seek_idx),
    .tag_i       (tag),
    .compute_i   (compute),
    .bypass_i    (bypass),
    .fail_i      (fail_evt),
    .nom_div_i   (nom_div_i),
    .margin_i    (margin_sel_i),
    .avg_en_i    (avg_en_i),
    .keep_en_i   (keep_en_i),
    .div_o       (div_o),
    .est_a_o     (est_a_o),
    .est_b_o     (est_b_o),
    .first_tag_o (first_tag_o)
  );

  assign state_o = 4'(state);
endmodule

// File: tb/zxc_calibrator_tb.sv
module zxc_calibrator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [15:0] nom;
    logic [2:0]  pulses;
    logic [1:0]  sel;
    logic [15:0] half;
    logic [7:0]  thr;
    logic [15:0] glitch;
    logic [3:0]  margin;
    logic        avg;
    logic [15:0] ediv;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [15:0] etag;
    logic        efail;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd40, 3'd0, 2'd0, 16'd20, 8'd4, 16'hFFFF, 4'd0, 1'b0, 16'd40, 16'd40, 16'd40, 16'd18, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd21, 8'd4, 16'hFFFF, 4'd5, 1'b0, 16'd42, 16'd42, 16'd42, 16'd21, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd21, 8'd4, 16'hFFFF, 4'd4, 1'b0, 16'd40, 16'd42, 16'd42, 16'd21, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd20, 8'd3, 16'd118,  4'd0, 1'b1, 16'd39, 16'd40, 16'd39, 16'd17, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd20, 8'd3, 16'd118,  4'd0, 1'b0, 16'd40, 16'd40, 16'd39, 16'd17, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd40, 8'd4, 16'hFFFF, 4'd0, 1'b0, 16'd40, 16'd80, 16'd0,  16'd38, 1'b1},
    '{16'd40, 3'd1, 2'd0, 16'd21, 8'd4, 16'hFFFF, 4'd0, 1'b0, 16'd42, 16'd42, 16'd42, 16'd23, 1'b0},
    '{16'd40, 3'd0, 2'd3, 16'd20, 8'd4, 16'hFFFF, 4'd0, 1'b0, 16'd40, 16'd40, 16'd40, 16'd22, 1'b0},
    '{16'd40, 3'd0, 2'd0, 16'd20, 8'd0, 16'hFFFF, 4'd0, 1'b0, 16'd40, 16'd40, 16'd40, 16'd15, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1, start_i = 1'b0, pwm_tick_i = 1'b0, bemf_cmp_i = 1'b0;
  logic [15:0] nom_div_i = 16'd40;
  logic [1:0]  dly_sel_i = 2'd0;
  logic [7:0]  zx_thresh_i = 8'd4;
  logic [3:0]  margin_sel_i = 4'd0;
  logic        avg_en_i = 1'b0, cal_en_i = 1'b1, keep_en_i = 1'b0;
  logic [2:0]  drive_pulses_i = 3'd0;
  logic [15:0] div_o, est_a_o, est_b_o, first_tag_o;
  logic [7:0]  hi_cnt_o, lo_cnt_o, lvl_cnt_o;
  logic        last_lvl_o, first_cal_o, fail_o;
  logic [3:0]  state_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zxc_calibrator u_dut (
    .clk_i, .rst_ni, .en_i, .start_i, .pwm_tick_i, .bemf_cmp_i, .nom_div_i,
    .dly_sel_i, .zx_thresh_i, .margin_sel_i, .avg_en_i, .cal_en_i, .keep_en_i,
    .drive_pulses_i, .div_o, .est_a_o, .est_b_o, .first_tag_o, .hi_cnt_o,
    .lo_cnt_o, .lvl_cnt_o, .last_lvl_o, .first_cal_o, .state_o, .fail_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one start strobe, then ticks every second clock until done or fail
  task automatic run_event(input int half, input int glitch, input bit flat);
    int g;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    g = 0;
    while (state_o != 4'd8 && state_o != 4'd9 && g < 3000) begin
      bemf_cmp_i = flat ? 1'b0 : (((g / half) % 2) == 1) ^ (g == glitch);
      pwm_tick_i = 1'b1;
      @(negedge clk_i) pwm_tick_i = 1'b0;
      @(negedge clk_i);
      g++;
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1 state", int'(state_o), 0);
    chk("R1 div", int'(div_o), 0);
    chk("R1 fail", int'(fail_o), 0);
    chk("R1 first", int'(first_cal_o), 1);
    chk("R1 counters", int'(hi_cnt_o) + int'(lo_cnt_o) + int'(lvl_cnt_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      nom_div_i      = VECS[i].nom;
      drive_pulses_i = VECS[i].pulses;
      dly_sel_i      = VECS[i].sel;
      zx_thresh_i    = VECS[i].thr;
      margin_sel_i   = VECS[i].margin;
      avg_en_i       = VECS[i].avg;
      cal_en_i       = 1'b1;
      run_event(int'(VECS[i].half), int'(VECS[i].glitch), 1'b0);
      // R2 R8 end state; R3 R4 first tag; R5 estimates; R6 R7 divisor
      chk($sformatf("R2/R8 vec%0d state", i), int'(state_o), VECS[i].efail ? 9 : 8);
      chk($sformatf("R8 vec%0d fail", i), int'(fail_o), int'(VECS[i].efail));
      chk($sformatf("R4 vec%0d first_tag", i), int'(first_tag_o), int'(VECS[i].etag));
      chk($sformatf("R5 vec%0d est_a", i), int'(est_a_o), int'(VECS[i].ea));
      if (!VECS[i].efail)
        chk($sformatf("R5 vec%0d est_b", i), int'(est_b_o), int'(VECS[i].eb));
      chk($sformatf("R6/R7 vec%0d div", i), int'(div_o), int'(VECS[i].ediv));
      if (i == 0) chk("R12 first cleared", int'(first_cal_o), 0);
    end

    // R11 counts while seeking crossing 1, post-crossing level state
    nom_div_i = 16'd40; drive_pulses_i = 3'd0; dly_sel_i = 2'd0;
    zx_thresh_i = 8'd4; margin_sel_i = 4'd0; avg_en_i = 1'b0;
    run_event(20, -1, 1'b0);
    chk("R11 hi count", int'(hi_cnt_o), 4);
    chk("R11 lo count", int'(lo_cnt_o), 15);
    chk("R11 lvl cleared", int'(lvl_cnt_o), 0);
    chk("R11 last level", int'(last_lvl_o), 0);

    // R11 saturation on a flat comparator, R8 timeout
    nom_div_i = 16'd100;
    run_event(1, -1, 1'b1);
    chk("R11 lo saturates", int'(lo_cnt_o), 255);
    chk("R11 hi stays", int'(hi_cnt_o), 0);
    chk("R8 flat fail", int'(state_o), 9);
    chk("R8 flat div", int'(div_o), 100);

    // R9 bypass without keep
    nom_div_i = 16'd40; cal_en_i = 1'b0; keep_en_i = 1'b0;
    run_event(20, -1, 1'b0);
    chk("R9 bypass state", int'(state_o), 8);
    chk("R9 bypass div", int'(div_o), 40);
    chk("R8 start clears fail", int'(fail_o), 0);

    // R10 keep accepted divisor, reuse on bypass
    cal_en_i = 1'b1; keep_en_i = 1'b1;
    run_event(21, -1, 1'b0);
    chk("R10 measured", int'(div_o), 42);
    cal_en_i = 1'b0;
    run_event(21, -1, 1'b0);
    chk("R10 kept reused", int'(div_o), 42);
    keep_en_i = 1'b0;
    run_event(21, -1, 1'b0);
    chk("R10 keep off uses nominal", int'(div_o), 40);

    // R2 enable drop
    cal_en_i = 1'b1;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk("R2 drive code", int'(state_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R2 enable low idle", int'(state_o), 0);
    en_i = 1'b1;
    @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule